// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block sits on a host register bus and lets software reach a downstream bus through a small indirect window. Software first stores a target address in an address register. A later access to one of two data windows then starts exactly one downstream cycle. The window that is hit picks the space: one window makes configuration cycles, the other makes I/O-port cycles. The low bits of the host offset, together with the access size, choose the byte lanes.

The host side is a simple request/acknowledge handshake. The host holds `h_req` and its fields until `h_ack` pulses for one cycle. A data-window access stalls the host until the downstream side signals completion. Read data comes back in the lanes of the original access, with all other lanes zero. The address register is not cleared by data accesses, so repeated accesses to the same target need only one address write.

Top module: `cfg_io_window`

## Requirements
- R1: After reset `h_ack` and `dn_valid` are low and the address register reads back as zero.
- R2: Any write to the address register offset (0x064..0x067, any size) stores the full 32-bit `h_wdata`. A read there returns the stored value. The value is kept across later data-window accesses.
- R3: An access to the configuration window (0x068..0x06B) drives `dn_io`=0 and `dn_addr` = {8'h00, addr_reg[23:2], 2'b00}. Bits 23:16 carry the bus, bits 15:8 the device/function and bits 7:2 the dword register index.
- R4: An access to the I/O-port window (0x06C..0x06F) drives `dn_io`=1 and `dn_addr` = {16'h0000, addr_reg[15:0]}.
- R5: Byte enables follow `h_size` and the low offset bits. For size 0 (byte) the enable is 1 << ofs[1:0]. For size 1 (halfword) it is 4'b0011 when ofs[1]=0 and 4'b1100 when ofs[1]=1. For size 2 (word) it is 4'b1111.
- R6: On a data-window write, `dn_write`=1 and `dn_wdata` equals `h_wdata` unchanged, because the host places data in its lanes.
- R7: On a data-window read, `h_rdata` equals `dn_rdata` with every disabled lane forced to zero. It is presented with `h_ack` in the cycle after `dn_done`.
- R8: Each accepted data-window access raises `dn_valid` exactly once. `dn_valid` and its fields stay unchanged until `dn_done`, and `h_ack` follows only after `dn_done`.
- R9: A halfword access with ofs[0]=1, or any access with `h_size`=3, to a data window is acknowledged with `h_err`=1 and starts no downstream cycle.
- R10: An access to any other offset is acknowledged with `h_err`=1. It starts no downstream cycle and leaves the address register unchanged.
- R11: An address-register access is acknowledged in the cycle after `h_req` is sampled. `h_ack` is a one-cycle pulse. A request still held during the acknowledge cycle is not taken as a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request, held until acknowledged |
| h_write | input | 1 | 1 = host write, 0 = host read |
| h_ofs | input | OFS_W | Host byte offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| h_wdata | input | DW | Host write data in its lanes |
| h_ack | output | 1 | One-cycle acknowledge |
| h_rdata | output | DW | Read data, valid with h_ack |
| h_err | output | 1 | Access rejected, valid with h_ack |
| dn_valid | output | 1 | Downstream cycle request |
| dn_io | output | 1 | 0 configuration cycle, 1 I/O-port cycle |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | DW | Downstream address |
| dn_be | output | DW/8 | Downstream byte enables |
| dn_wdata | output | DW | Downstream write data |
| dn_done | input | 1 | Downstream cycle complete |
| dn_rdata | input | DW | Downstream read data, valid with dn_done |

## Verification
Two events can share a cycle. The first pair is a downstream completion and the very first cycle of its request: the bench responder can answer with no wait state, so `dn_done` is seen while `dn_valid` has only just risen. The second pair is the acknowledge cycle and a host request that is still held. The bench keeps `h_req` high through the acknowledge edge. It then judges from the ports that no second downstream cycle or acknowledge appears, and that returned lanes and the address register are still correct after each overlap.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [1:0] {
        TGT_AREG = 2'd0,
        TGT_CFG  = 2'd1,
        TGT_IO   = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int OFS_W    = 12,
    parameter int NB       = 4,
    parameter int AREG_OFS = 'h064,
    parameter int CFG_OFS  = 'h068,
    parameter int IO_OFS   = 'h06C
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output tgt_e             tgt,
    output logic [NB-1:0]    be,
    output logic             bad_align
);
    localparam int LB = $clog2(NB);
    localparam logic [OFS_W-1:0] AREG_V = OFS_W'(AREG_OFS);
    localparam logic [OFS_W-1:0] CFG_V  = OFS_W'(CFG_OFS);
    localparam logic [OFS_W-1:0] IO_V   = OFS_W'(IO_OFS);

    logic [OFS_W-LB-1:0] word_idx;
    assign word_idx = ofs[OFS_W-1:LB];

    always_comb begin
        if (word_idx == AREG_V[OFS_W-1:LB])
            tgt = TGT_AREG;
        else if (word_idx == CFG_V[OFS_W-1:LB])
            tgt = TGT_CFG;
        else if (word_idx == IO_V[OFS_W-1:LB])
            tgt = TGT_IO;
        else
            tgt = TGT_NONE;
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [LB-1:0] LANE = LB'(i);
        always_comb begin
            case (size)
                SZ_BYTE: be[i] = (ofs[LB-1:0] == LANE);
                SZ_HALF: be[i] = (ofs[LB-1:1] == LANE[LB-1:1]);
                SZ_WORD: be[i] = 1'b1;
                default: be[i] = 1'b0;
            endcase
        end
    end

    assign bad_align = (size == 2'd3) || ((size == SZ_HALF) && ofs[0]);

endmodule

// File: rtl/cfgwin_dnaddr.sv
module cfgwin_dnaddr #(
    parameter int DW     = 32,
    parameter int CFG_W  = 24,
    parameter int PORT_W = 16
) (
    input  logic [DW-1:0] areg,
    input  logic          is_io,
    output logic [DW-1:0] addr
);
    logic [DW-1:0] cfg_addr;
    logic [DW-1:0] io_addr;

    always_comb begin
        cfg_addr             = '0;
        cfg_addr[CFG_W-1:2]  = areg[CFG_W-1:2];
        io_addr              = '0;
        io_addr[PORT_W-1:0]  = areg[PORT_W-1:0];
        addr                 = is_io ? io_addr : cfg_addr;
    end

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes #(
    parameter int NB = 4
) (
    input  logic [NB-1:0]   be,
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign dout[i*8 +: 8] = be[i] ? din[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/cfg_io_window.sv
module cfg_io_window
    import cfgwin_pkg::*;
#(
    parameter int OFS_W    = 12,
    parameter int DW       = 32,
    parameter int AREG_OFS = 'h064,
    parameter int CFG_OFS  = 'h068,
    parameter int IO_OFS   = 'h06C,
    parameter int CFG_W    = 24,
    parameter int PORT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_req,
    input  logic             h_write,
    input  logic [OFS_W-1:0] h_ofs,
    input  logic [1:0]       h_size,
    input  logic [DW-1:0]    h_wdata,
    output logic             h_ack,
    output logic [DW-1:0]    h_rdata,
    output logic             h_err,
    output logic             dn_valid,
    output logic             dn_io,
    output logic             dn_write,
    output logic [DW-1:0]    dn_addr,
    output logic [DW/8-1:0]  dn_be,
    output logic [DW-1:0]    dn_wdata,
    input  logic             dn_done,
    input  logic [DW-1:0]    dn_rdata
);
    localparam int NB = DW / 8;

    typedef struct packed {
        st_e           st;
        logic [DW-1:0] areg;
        logic          valid;
        logic          io;
        logic          write;
        logic [DW-1:0] addr;
        logic [NB-1:0] be;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          err;
    } win_t;

    win_t q, d;

    tgt_e          tgt;
    logic [NB-1:0] acc_be;
    logic          bad_align;
    logic [DW-1:0] fmt_addr;
    logic [DW-1:0] lane_rdata;

    cfgwin_decode #(
        .OFS_W(OFS_W), .NB(NB), .AREG_OFS(AREG_OFS),
        .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
    ) u_decode (
        .ofs(h_ofs), .size(h_size), .tgt(tgt),
        .be(acc_be), .bad_align(bad_align)
    );

    cfgwin_dnaddr #(.DW(DW), .CFG_W(CFG_W), .PORT_W(PORT_W)) u_dnaddr (
        .areg(q.areg), .is_io(tgt == TGT_IO), .addr(fmt_addr)
    );

    cfgwin_lanes #(.NB(NB)) u_lanes (
        .be(q.be), .din(dn_rdata), .dout(lane_rdata)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (h_req) begin
                    d.err   = 1'b0;
                    d.rdata = '0;
                    case (tgt)
                        TGT_AREG: begin
                            if (h_write) d.areg  = h_wdata;
                            else         d.rdata = q.areg;
                            d.st = ST_ACK;
                        end
                        TGT_CFG, TGT_IO: begin
                            if (bad_align) begin
                                d.err = 1'b1;
                                d.st  = ST_ACK;
                            end else begin
                                d.valid = 1'b1;
                                d.io    = (tgt == TGT_IO);
                                d.write = h_write;
                                d.addr  = fmt_addr;
                                d.be    = acc_be;
                                d.wdata = h_write ? h_wdata : '0;
                                d.st    = ST_BUSY;
                            end
                        end
                        default: begin
                            d.err = 1'b1;
                            d.st  = ST_ACK;
                        end
                    endcase
                end
            end
            ST_BUSY: begin
                if (dn_done) begin
                    d.valid = 1'b0;
                    if (!q.write) d.rdata = lane_rdata;
                    d.st = ST_ACK;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign h_ack    = (q.st == ST_ACK);
    assign h_rdata  = q.rdata;
    assign h_err    = q.err;
    assign dn_valid = q.valid;
    assign dn_io    = q.io;
    assign dn_write = q.write;
    assign dn_addr  = q.addr;
    assign dn_be    = q.be;
    assign dn_wdata = q.wdata;

    // R8
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_done |=> dn_valid && $stable(dn_addr) && $stable(dn_be)
                                 && $stable(dn_io) && $stable(dn_write) && $stable(dn_wdata));

    // R8
    done_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_done |=> h_ack && !dn_valid);

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> !h_ack);

    // R5
    be_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ($countones(dn_be) == 1) || (dn_be == 4'b0011)
                     || (dn_be == 4'b1100) || (dn_be == 4'b1111));

    // R3
    cfg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_io |-> dn_addr[1:0] == 2'b00 && dn_addr[DW-1:CFG_W] == '0);

    // R9
    err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack && h_err |-> !dn_valid && !$past(dn_valid));

    // R8
    start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_valid) |-> $past(h_req) && !h_ack);

    // R2
    areg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.areg) |-> $past(h_req && h_write && tgt == TGT_AREG && q.st == ST_IDLE));

endmodule

// File: tb/cfg_io_window_bench.sv
module cfg_io_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic        h_write = 1'b0;
    logic [11:0] h_ofs = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ack;
    logic [31:0] h_rdata;
    logic        h_err;
    logic        dn_valid, dn_io, dn_write;
    logic [31:0] dn_addr;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        dn_done = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int          lat = 1;
    int          wcnt = 0;
    int          dn_count = 0;
    int          ack_count = 0;
    logic [31:0] model_rdata = 32'hA1B2C3D4;
    logic        cap_io, cap_write;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0]  cap_be;

    always #4 clk = ~clk;

    cfg_io_window u_cfg_io_window (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_write(h_write),
        .h_ofs(h_ofs), .h_size(h_size), .h_wdata(h_wdata),
        .h_ack(h_ack), .h_rdata(h_rdata), .h_err(h_err),
        .dn_valid(dn_valid), .dn_io(dn_io), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_done(dn_done), .dn_rdata(dn_rdata)
    );

    // downstream responder and acknowledge counter
    always @(negedge clk) begin
        if (h_ack) ack_count++;
        if (!rst_n) begin
            dn_done = 1'b0;
            wcnt = 0;
        end else if (dn_done) begin
            dn_done = 1'b0;
        end else if (dn_valid) begin
            if (wcnt >= lat) begin
                dn_done   = 1'b1;
                dn_rdata  = model_rdata;
                cap_io    = dn_io;
                cap_write = dn_write;
                cap_addr  = dn_addr;
                cap_be    = dn_be;
                cap_wdata = dn_wdata;
                dn_count++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, input bit hold_extra,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        h_req = 1'b1; h_write = w; h_ofs = ofs; h_size = sz; h_wdata = wd;
        for (int n = 0; n < 500; n++) begin
            @(negedge clk);
            if (h_ack) break;
        end
        rd = h_rdata;
        er = h_err;
        if (hold_extra) @(negedge clk);
        h_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic er;
        check("R1 ack low", {31'b0, h_ack}, 32'd0);
        check("R1 dn_valid low", {31'b0, dn_valid}, 32'd0);
        access(1'b0, 12'h064, 2'd2, '0, 0, rd, er);
        check("R1 addr reg zero", rd, 32'h0);
    endtask

    task automatic t_areg;
        logic [31:0] rd; logic er; int c0;
        c0 = dn_count;
        access(1'b1, 12'h064, 2'd2, 32'hFF12_3457, 0, rd, er);
        access(1'b0, 12'h064, 2'd2, '0, 0, rd, er);
        check("R2 readback", rd, 32'hFF12_3457);
        check("R2 no error", {31'b0, er}, 32'd0);
        check("R2 no dn cycle", dn_count - c0, 32'd0);
    endtask

    task automatic t_cfg_read;
        logic [31:0] rd; logic er; int c0;
        c0 = dn_count; lat = 3;
        access(1'b0, 12'h068, 2'd2, '0, 0, rd, er);
        check("R8 one cycle", dn_count - c0, 32'd1);
        check("R3 cfg type", {31'b0, cap_io}, 32'd0);
        check("R3 cfg addr", cap_addr, 32'h0012_3454);
        check("R5 word be", {28'b0, cap_be}, 32'hF);
        check("R7 word data", rd, 32'hA1B2C3D4);
    endtask

    task automatic t_cfg_bytes;
        logic [31:0] rd; logic er;
        lat = 0;
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 12'h068 + 12'(i), 2'd0, '0, 0, rd, er);
            check("R5 byte be", {28'b0, cap_be}, 32'(1 << i));
            check("R7 byte lane", rd, model_rdata & (32'hFF << (8 * i)));
        end
        access(1'b0, 12'h06A, 2'd1, '0, 0, rd, er);
        check("R5 half hi be", {28'b0, cap_be}, 32'hC);
        check("R7 half hi data", rd, 32'hA1B2_0000);
        access(1'b0, 12'h068, 2'd1, '0, 0, rd, er);
        check("R5 half lo be", {28'b0, cap_be}, 32'h3);
        check("R7 half lo data", rd, 32'h0000_C3D4);
    endtask

    task automatic t_io_write;
        logic [31:0] rd; logic er; int c0;
        c0 = dn_count; lat = 2;
        access(1'b1, 12'h06D, 2'd0, 32'h0000_5A00, 0, rd, er);
        check("R8 one io cycle", dn_count - c0, 32'd1);
        check("R4 io type", {31'b0, cap_io}, 32'd1);
        check("R4 io addr", cap_addr, 32'h0000_3457);
        check("R6 write dir", {31'b0, cap_write}, 32'd1);
        check("R6 write data", cap_wdata, 32'h0000_5A00);
        check("R5 io byte be", {28'b0, cap_be}, 32'h2);
    endtask

    task automatic t_misaligned;
        logic [31:0] rd; logic er; int c0;
        c0 = dn_count;
        access(1'b0, 12'h069, 2'd1, '0, 0, rd, er);
        check("R9 half odd err", {31'b0, er}, 32'd1);
        access(1'b1, 12'h06C, 2'd3, 32'h1, 0, rd, er);
        check("R9 size3 err", {31'b0, er}, 32'd1);
        check("R9 no dn cycle", dn_count - c0, 32'd0);
    endtask

    task automatic t_unmapped;
        logic [31:0] rd; logic er; int c0;
        c0 = dn_count;
        access(1'b1, 12'h070, 2'd2, 32'hDEAD_BEEF, 0, rd, er);
        check("R10 err", {31'b0, er}, 32'd1);
        check("R10 no dn cycle", dn_count - c0, 32'd0);
        access(1'b0, 12'h064, 2'd2, '0, 0, rd, er);
        check("R10 addr reg kept", rd, 32'hFF12_3457);
        check("R2 retained after data", rd, 32'hFF12_3457);
    endtask

    task automatic t_held_req;
        logic [31:0] rd; logic er; int c0, a0;
        c0 = dn_count; lat = 0;
        access(1'b0, 12'h06C, 2'd2, '0, 1, rd, er);
        a0 = ack_count;
        repeat (6) @(negedge clk);
        check("R11 held req no new cycle", dn_count - c0, 32'd1);
        check("R11 held req no new ack", ack_count - a0, 32'd0);
        check("R7 zero-wait data", rd, 32'hA1B2C3D4);
        c0 = dn_count;
        access(1'b0, 12'h064, 2'd0, '0, 1, rd, er);
        a0 = ack_count;
        repeat (4) @(negedge clk);
        check("R11 areg held no new ack", ack_count - a0, 32'd0);
        check("R11 areg read value", rd, 32'hFF12_3457);
    endtask

    task automatic t_areg_latency;
        int n;
        @(negedge clk);
        h_req = 1'b1; h_write = 1'b0; h_ofs = 12'h064; h_size = 2'd2;
        @(negedge clk);
        n = h_ack;
        @(negedge clk);
        h_req = 1'b0;
        check("R11 ack after one cycle", 32'(n), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_areg();
        t_cfg_read();
        t_cfg_bytes();
        t_io_write();
        t_misaligned();
        t_unmapped();
        t_held_req();
        t_areg_latency();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule